// File: doc/BRIEF.md
# In-Order Micro-Op Issue Bandwidth Controller

This block sits at the issue point of an in-order pipeline. It decides on every clock whether the instruction offered at its input may issue. The decision uses the instruction's micro-op count, its group-boundary flags, the issue slots still free in the current issue cycle, and whether an earlier wide instruction is still draining. An issue cycle is bounded by a `cycle_start` pulse. Between two pulses, several instructions can be offered on successive clocks, and each one takes slots from a budget of `ISSUE_W`.

An instruction with more micro-ops than the issue width can never fit in one cycle. It is therefore accepted even when the budget is short. Its remaining micro-ops are then drained at later cycle starts, and no new instruction is accepted while they drain. An instruction flagged to open a group may only take the first slot of a cycle. An instruction flagged to close a group ends the cycle's budget once it issues. A stall input blocks acceptance. A stall present at a cycle start also empties that cycle's budget. Hazard detection, execution and retirement belong to other blocks.

Top module: `uop_issue_ctrl`

## Requirements
- R1: After reset, `issued_cnt` is 0, `busy` is 0 and the full budget of `ISSUE_W` slots is free, so an instruction of exactly `ISSUE_W` micro-ops is accepted.
- R2: A `cycle_start` pulse with no leftover pending and no stall clears `issued_cnt` to 0 and reloads the budget to `ISSUE_W` on the next clock edge.
- R3: `issued_cnt` never exceeds `ISSUE_W`.
- R4: An offered instruction of n micro-ops, with n no larger than the free budget, is accepted. `issued_cnt` grows by n and the free budget shrinks by n.
- R5: An instruction with n ≤ `ISSUE_W` but n greater than the free budget is not accepted, and the state is unchanged.
- R6: An instruction with n > `ISSUE_W` is accepted whatever the free budget. `issued_cnt` grows by the free budget, the budget becomes 0, the leftover (n minus the free budget) is stored, and `busy` goes to 1.
- R7: At a `cycle_start` with leftover L pending, if L > `ISSUE_W` then L shrinks by `ISSUE_W`, `issued_cnt` becomes `ISSUE_W`, the budget becomes 0 and `busy` stays 1. Otherwise the leftover clears, `busy` drops, `issued_cnt` becomes L, and the budget becomes `ISSUE_W`−L, or 0 if the wide instruction carried the group-close flag.
- R8: An instruction with the group-open flag (`in_begin_grp`=1) is accepted only while `issued_cnt` is 0.
- R9: When an instruction with the group-close flag (`in_end_grp`=1) is accepted, the free budget becomes 0 for the rest of the cycle.
- R10: While `stall_act` is 1 nothing is accepted. A `cycle_start` taken with `stall_act`=1 leaves a budget of 0 for that cycle.
- R11: A micro-op count of 0 is handled as a count of 1.
- R12: No instruction is accepted on a clock where `cycle_start` is 1.
- R13: While `busy` is 1 no instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_start | input | 1 | Pulse marking the start of an issue cycle |
| in_valid | input | 1 | An instruction is offered |
| in_uops | input | UOP_W | Micro-op count of the offered instruction (0 means 1) |
| in_begin_grp | input | 1 | Instruction must take the first slot of a cycle |
| in_end_grp | input | 1 | Instruction closes the cycle once issued |
| stall_act | input | 1 | External stall: block acceptance |
| accept | output | 1 | The offered instruction issues on this clock |
| issued_cnt | output | clog2(ISSUE_W+1) | Slots used in the current issue cycle |
| busy | output | 1 | Leftover micro-ops of a wide instruction still pending |

## Verification
The bench builds the block with `ISSUE_W`=4 and `UOP_W`=4. With these values a 4-bit count can exceed the width by more than two cycles' worth. A count of 10 therefore drains over a partial cycle and then an exactly-full completing cycle. Counts of 5 to 7 reach the completing branch with leftovers of 1 to 4. The same width also allows an exact fit, a one-slot shortfall, and a wide instruction offered when the budget is already 0.

// File: rtl/uop_issue_pkg.sv
// Package: shared types for the micro-op issue bandwidth controller.
// Assumes: nothing beyond IEEE 1800-2017.
package uop_issue_pkg;

    // What a cycle start does with a pending leftover of a wide instruction.
    typedef enum logic [1:0] {
        CS_FRESH      = 2'd0,  // nothing pending: full budget
        CS_PARTIAL    = 2'd1,  // leftover exceeds width: whole cycle consumed
        CS_DONE       = 2'd2,  // leftover completes, rest of budget free
        CS_DONE_CLOSE = 2'd3   // leftover completes and closes the cycle
    } carry_step_e;

endpackage

// File: rtl/uop_normalize.sv
// Module: uop_normalize
// Maps a raw micro-op count to its effective value (zero counts as one)
// and flags counts that exceed the issue width.
// Assumes: UOP_W is wide enough to hold ISSUE_W.
module uop_normalize #(
    parameter int ISSUE_W = 4,
    parameter int UOP_W   = 4
) (
    input  logic [UOP_W-1:0] raw_uops,
    output logic [UOP_W-1:0] eff_uops,
    output logic             is_wide
);

    localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(ISSUE_W);

    // Purpose: substitute one for a zero count and compare against the width.
    always_comb begin
        eff_uops = (raw_uops == '0) ? UOP_W'(1) : raw_uops;
        is_wide  = eff_uops > WIDTH_U;
    end

endmodule

// File: rtl/uop_carry_tracker.sv
// Module: uop_carry_tracker
// Holds the leftover micro-ops of an instruction wider than the free
// budget and drains them at each cycle start, ISSUE_W at a time.
// Assumes: take only asserts while no leftover is pending and never on a
// cycle_start clock (guaranteed by the accept gate).
module uop_carry_tracker
    import uop_issue_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int UOP_W   = 4,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_start,
    input  logic             take,
    input  logic [UOP_W-1:0] eff_uops,
    input  logic             end_grp,
    input  logic [CNT_W-1:0] bw_now,
    output carry_step_e      step,
    output logic [CNT_W-1:0] step_used,
    output logic             pending
);

    localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(ISSUE_W);
    localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(ISSUE_W);

    logic [UOP_W-1:0] left_q;
    logic             left_end_q;
    logic [UOP_W-1:0] bw_ext;

    assign bw_ext  = UOP_W'(bw_now);
    assign pending = (left_q != '0);

    // Purpose: classify what the next cycle start does with the leftover.
    always_comb begin
        if (left_q == '0) begin
            step      = CS_FRESH;
            step_used = '0;
        end else if (left_q > WIDTH_U) begin
            step      = CS_PARTIAL;
            step_used = WIDTH_C;
        end else begin
            step      = left_end_q ? CS_DONE_CLOSE : CS_DONE;
            step_used = CNT_W'(left_q);
        end
    end

    // Purpose: load a new leftover on a wide accept, drain it at cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q     <= '0;
            left_end_q <= 1'b0;
        end else if (cycle_start) begin
            if (step == CS_PARTIAL) begin
                left_q <= left_q - WIDTH_U;
            end else begin
                left_q <= '0;
            end
        end else if (take && (eff_uops > bw_ext)) begin
            left_q     <= eff_uops - bw_ext;
            left_end_q <= end_grp;
        end
    end

endmodule

// File: rtl/uop_slot_ledger.sv
// Module: uop_slot_ledger
// Keeps the free issue budget and the used-slot count of the current
// issue cycle. Reloads them at each cycle start and charges each accept.
// Assumes: used + free never exceeds ISSUE_W, which the accept gate keeps.
module uop_slot_ledger
    import uop_issue_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int UOP_W   = 4,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_start,
    input  logic             stall_act,
    input  carry_step_e      step,
    input  logic [CNT_W-1:0] step_used,
    input  logic             take,
    input  logic [UOP_W-1:0] eff_uops,
    input  logic             end_grp,
    output logic [CNT_W-1:0] bw_q,
    output logic [CNT_W-1:0] used_q
);

    localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(ISSUE_W);

    logic [CNT_W-1:0] start_used;
    logic [CNT_W-1:0] start_bw;
    logic             fits;

    assign fits = (eff_uops <= UOP_W'(bw_q));

    // Purpose: compute the budget and used count that a cycle start loads.
    always_comb begin
        unique case (step)
            CS_PARTIAL: begin
                start_used = WIDTH_C;
                start_bw   = '0;
            end
            CS_DONE: begin
                start_used = step_used;
                start_bw   = WIDTH_C - step_used;
            end
            CS_DONE_CLOSE: begin
                start_used = step_used;
                start_bw   = '0;
            end
            default: begin
                start_used = '0;
                start_bw   = WIDTH_C;
            end
        endcase
        if (stall_act) begin
            start_bw = '0;
        end
    end

    // Purpose: reload at cycle start, charge slots on each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
            bw_q   <= WIDTH_C;
        end else if (cycle_start) begin
            used_q <= start_used;
            bw_q   <= start_bw;
        end else if (take) begin
            if (fits) begin
                used_q <= used_q + CNT_W'(eff_uops);
                bw_q   <= end_grp ? '0 : bw_q - CNT_W'(eff_uops);
            end else begin
                used_q <= used_q + bw_q;
                bw_q   <= '0;
            end
        end
    end

endmodule

// File: rtl/uop_accept_gate.sv
// Module: uop_accept_gate
// Combinational issue decision for the offered instruction.
// Assumes: eff_uops is already normalised (never zero).
module uop_accept_gate #(
    parameter int UOP_W = 4,
    parameter int CNT_W = 3
) (
    input  logic             in_valid,
    input  logic             cycle_start,
    input  logic             stall_act,
    input  logic             pending,
    input  logic             is_wide,
    input  logic             begin_grp,
    input  logic [UOP_W-1:0] eff_uops,
    input  logic [CNT_W-1:0] bw_q,
    input  logic [CNT_W-1:0] used_q,
    output logic             accept
);

    logic room_ok;
    logic group_ok;

    // Purpose: combine budget, grouping and blocking conditions.
    always_comb begin
        room_ok  = is_wide || (eff_uops <= UOP_W'(bw_q));
        group_ok = !begin_grp || (used_q == '0);
        accept   = in_valid && !cycle_start && !stall_act && !pending
                   && room_ok && group_ok;
    end

endmodule

// File: rtl/uop_issue_ctrl.sv
// Module: uop_issue_ctrl (top)
// In-order micro-op issue bandwidth controller: decides per clock whether the
// offered instruction issues within the ISSUE_W-slot budget of the current
// issue cycle, spreading over-wide instructions across cycle starts.
// Assumes: 1 <= ISSUE_W <= 8, UOP_W large enough to hold ISSUE_W.
module uop_issue_ctrl
    import uop_issue_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int UOP_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cycle_start,
    input  logic                           in_valid,
    input  logic [UOP_W-1:0]               in_uops,
    input  logic                           in_begin_grp,
    input  logic                           in_end_grp,
    input  logic                           stall_act,
    output logic                           accept,
    output logic [$clog2(ISSUE_W+1)-1:0]   issued_cnt,
    output logic                           busy
);

    localparam int CNT_W = $clog2(ISSUE_W + 1);

    logic [UOP_W-1:0] eff_uops;
    logic             is_wide;
    carry_step_e      step;
    logic [CNT_W-1:0] step_used;
    logic             pending;
    logic [CNT_W-1:0] bw_q;
    logic [CNT_W-1:0] used_q;

    uop_normalize #(.ISSUE_W(ISSUE_W), .UOP_W(UOP_W)) u_norm (
        .raw_uops (in_uops),
        .eff_uops (eff_uops),
        .is_wide  (is_wide)
    );

    uop_accept_gate #(.UOP_W(UOP_W), .CNT_W(CNT_W)) u_gate (
        .in_valid    (in_valid),
        .cycle_start (cycle_start),
        .stall_act   (stall_act),
        .pending     (pending),
        .is_wide     (is_wide),
        .begin_grp   (in_begin_grp),
        .eff_uops    (eff_uops),
        .bw_q        (bw_q),
        .used_q      (used_q),
        .accept      (accept)
    );

    uop_carry_tracker #(.ISSUE_W(ISSUE_W), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_carry (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .take        (accept),
        .eff_uops    (eff_uops),
        .end_grp     (in_end_grp),
        .bw_now      (bw_q),
        .step        (step),
        .step_used   (step_used),
        .pending     (pending)
    );

    uop_slot_ledger #(.ISSUE_W(ISSUE_W), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_ledger (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .stall_act   (stall_act),
        .step        (step),
        .step_used   (step_used),
        .take        (accept),
        .eff_uops    (eff_uops),
        .end_grp     (in_end_grp),
        .bw_q        (bw_q),
        .used_q      (used_q)
    );

    assign issued_cnt = used_q;
    assign busy       = pending;

endmodule

// File: rtl/uop_issue_ctrl_chk.sv
// Module: uop_issue_ctrl_chk
// Assertion checker for uop_issue_ctrl, attached by bind below.
// Assumes: observes only the top-level ports.
module uop_issue_ctrl_chk #(
    parameter int ISSUE_W = 4,
    parameter int UOP_W   = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cycle_start,
    input logic                         in_valid,
    input logic [UOP_W-1:0]             in_uops,
    input logic                         in_begin_grp,
    input logic                         stall_act,
    input logic                         accept,
    input logic [$clog2(ISSUE_W+1)-1:0] issued_cnt,
    input logic                         busy
);

    localparam int CNT_W = $clog2(ISSUE_W + 1);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        issued_cnt <= CNT_W'(ISSUE_W));

    a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        stall_act |-> !accept);

    a_r13_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

    a_r12_no_accept_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> !accept);

    a_r8_begin_first: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_begin_grp) |-> (issued_cnt == '0));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !busy) |=> (issued_cnt == '0));

    a_r6_busy_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> !busy);

    a_r11_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> in_valid);

endmodule

bind uop_issue_ctrl uop_issue_ctrl_chk #(.ISSUE_W(ISSUE_W), .UOP_W(UOP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cycle_start  (cycle_start),
    .in_valid     (in_valid),
    .in_uops      (in_uops),
    .in_begin_grp (in_begin_grp),
    .stall_act    (stall_act),
    .accept       (accept),
    .issued_cnt   (issued_cnt),
    .busy         (busy)
);

// File: tb/uop_issue_ctrl_tb.sv
module uop_issue_ctrl_tb;

    localparam int W  = 4;
    localparam int UW = 4;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        bit       cs;
        bit       v;
        bit [3:0] u;
        bit       b;
        bit       e;
        bit       st;
        bit       acc;
        bit [3:0] iss;
        bit       bsy;
        bit [3:0] rq;
    } vec_t;

    localparam int NV = 42;
    // fields: cs v uops beg end stall | accept issued busy | requirement
    localparam vec_t VECS [NV] = '{
        '{1,0, 0,0,0,0, 0,0,0,  2},  // R2 fresh cycle
        '{0,1, 1,0,0,0, 1,1,0,  4},  // R4
        '{0,1, 2,0,0,0, 1,3,0,  4},  // R4
        '{0,1, 2,0,0,0, 0,3,0,  5},  // R5 only one slot left
        '{0,1, 1,1,0,0, 0,3,0,  8},  // R8 begin after slots used
        '{0,1, 1,0,0,0, 1,4,0,  4},  // R4 fills cycle
        '{1,1, 1,0,0,0, 0,0,0, 12},  // R12 no accept at start
        '{0,1, 0,0,0,0, 1,1,0, 11},  // R11 zero counts as one
        '{0,1, 1,0,1,0, 1,2,0,  9},  // R9 end-group
        '{0,1, 1,0,0,0, 0,2,0,  9},  // R9 cycle closed
        '{1,0, 0,0,0,0, 0,0,0,  2},
        '{0,1, 2,1,0,0, 1,2,0,  8},  // R8 begin at slot zero
        '{0,1,10,0,0,0, 1,4,1,  6},  // R6 wide, leftover 8
        '{0,1, 1,0,0,0, 0,4,1, 13},  // R13 busy blocks
        '{1,0, 0,0,0,0, 0,4,1,  7},  // R7 partial, leftover 4
        '{0,1, 1,0,0,0, 0,4,1, 13},  // R13
        '{1,0, 0,0,0,0, 0,4,0,  7},  // R7 completes exactly, budget 0
        '{0,1, 1,0,0,0, 0,4,0,  7},  // R7 no room
        '{1,0, 0,0,0,0, 0,0,0,  2},
        '{0,1, 7,0,1,0, 1,4,1,  6},  // R6 wide end-group, leftover 3
        '{1,0, 0,0,0,0, 0,3,0,  7},  // R7 completes, closes
        '{0,1, 1,0,0,0, 0,3,0,  7},  // R7 closed cycle
        '{1,0, 0,0,0,0, 0,0,0,  2},
        '{0,1, 6,0,0,0, 1,4,1,  6},  // R6 leftover 2
        '{1,0, 0,0,0,0, 0,2,0,  7},  // R7 completes, 2 free
        '{0,1, 2,0,0,0, 1,4,0,  7},  // R7 uses remaining budget
        '{1,0, 0,0,0,1, 0,0,0, 10},  // R10 stall at cycle start
        '{0,1, 1,0,0,0, 0,0,0, 10},  // R10 budget zero after stall start
        '{1,0, 0,0,0,0, 0,0,0,  2},
        '{0,1, 1,0,0,1, 0,0,0, 10},  // R10 stall blocks
        '{0,1, 1,0,0,0, 1,1,0,  4},
        '{0,1, 4,0,0,0, 0,1,0,  5},  // R5 fits width, not budget
        '{1,0, 0,0,0,0, 0,0,0,  2},
        '{0,1, 4,0,0,0, 1,4,0,  4},  // R4 exact fit
        '{0,1, 5,0,0,0, 1,4,1,  6},  // R6 wide with zero budget, leftover 5
        '{1,0, 0,0,0,0, 0,4,1,  7},  // R7 partial, leftover 1
        '{1,0, 0,0,0,0, 0,1,0,  7},  // R7 completes, 3 free
        '{0,1, 3,0,0,0, 1,4,0,  7},  // R7 three slots were free
        '{1,0, 0,0,0,0, 0,0,0,  2},
        '{0,1, 3,0,0,0, 1,3,0,  4},
        '{0,1, 5,0,0,0, 1,4,1,  6},  // R6 leftover 4
        '{1,0, 0,0,0,0, 0,4,0,  7}   // R7 completes exactly
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cycle_start = 1'b0;
    logic          in_valid = 1'b0;
    logic [UW-1:0] in_uops = '0;
    logic          in_begin_grp = 1'b0;
    logic          in_end_grp = 1'b0;
    logic          stall_act = 1'b0;
    logic          accept;
    logic [CW-1:0] issued_cnt;
    logic          busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    uop_issue_ctrl #(.ISSUE_W(W), .UOP_W(UW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cycle_start  (cycle_start),
        .in_valid     (in_valid),
        .in_uops      (in_uops),
        .in_begin_grp (in_begin_grp),
        .in_end_grp   (in_end_grp),
        .stall_act    (stall_act),
        .accept       (accept),
        .issued_cnt   (issued_cnt),
        .busy         (busy)
    );

    task automatic check(input string what, input int rq, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t vv);
        cycle_start  = vv.cs;
        in_valid     = vv.v;
        in_uops      = vv.u;
        in_begin_grp = vv.b;
        in_end_grp   = vv.e;
        stall_act    = vv.st;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and full budget
        @(negedge clk);
        #1;
        check("reset issued_cnt", 1, int'(issued_cnt), 0);
        check("reset busy", 1, int'(busy), 0);
        drive('{0,1,4,0,0,0,0,0,0,1});
        #1;
        check("full budget after reset", 1, int'(accept), 1);
        drive('0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            check($sformatf("vec %0d accept", i), int'(VECS[i].rq), int'(accept), int'(VECS[i].acc));
            @(posedge clk);
            #1;
            check($sformatf("vec %0d issued_cnt", i), int'(VECS[i].rq), int'(issued_cnt), int'(VECS[i].iss));
            check($sformatf("vec %0d busy", i), int'(VECS[i].rq), int'(busy), int'(VECS[i].bsy));
        end

        // R1 reset while a leftover is pending
        @(negedge clk);
        drive('{1,0,0,0,0,0,0,0,0,1});
        @(negedge clk);
        drive('{0,1,9,0,0,0,0,0,0,1});
        @(negedge clk);
        drive('0);
        #1;
        check("busy before reset", 6, int'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("busy after reset", 1, int'(busy), 0);
        check("issued after reset", 1, int'(issued_cnt), 0);
        drive('{0,1,4,0,0,0,0,0,0,1});
        #1;
        check("accept after reset", 1, int'(accept), 1);
        drive('0);

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule